// File: doc/BRIEF.md
# Power-Manager Pin Router

This block sets the role of three pins on a power-management controller. Two of the pins can act as inputs. The third pin is output-only. Static configuration bits choose the role of each pin. Each pin drive is shown as an output-enable and output-value pair, so the pad model outside the block does the real tristating.

**First pin.** It is an open-drain output that a user bit or a sequencer override controls. It can also become an input that carries the host's memory-reset signal.

**Second pin.** It is an output that uses either open-drain or push-pull buffering. In one mode its user bit drives it. In the other mode it repeats the memory-reset level from the first pin while the internal power-good signal is high. When power-good falls, it holds the last value it repeated. After power-on reset it is held low.

**Third pin.** It is an open-drain output that a user bit or a sequencer override controls. It can also become an active-low reset input for two converters. In that case the block reports a registered active-high reset request.

**Clock domains.** Power-good, the first pin's input and the third pin's input are asynchronous to the system clock. Each one passes through a synchronizer before the block uses it.

Top module: `pmic_pin_router`

## Requirements
- R1: When `cfgIo1Sel`=0, the first pin is an open-drain output. A drive value of 0 gives `pin1Oe`=1 and `pin1Out`=0. A drive value of 1 gives `pin1Oe`=0. The drive value is `userGpo1`.
- R2: When `seqOvr1`=1, `seqVal1` replaces `userGpo1` as the first pin's drive value. When `seqOvr3`=1, `seqVal3` replaces `userGpo3` as the third pin's drive value.
- R3: When `cfgIo1Sel`=1:
  - The first pin is released (`pin1Oe`=0).
  - While `pgoodIn` is high, the second pin's level follows `pin1In` within 4 clock cycles.
- R4: On a falling edge of `pgoodIn`, the second pin's level freezes at its current value. The frozen level holds while power-good stays low. Changes on `pin1In` during that time have no effect.
- R5: After the asynchronous reset `rst_n`, the held second-pin level is 0. With `cfgIo1Sel`=1 and `pgoodIn` low, the second pin drives a logic low.
- R6: When `cfgIo1Sel`=0, the second pin's level is `userGpo2`. `pin1In` and `pgoodIn` have no effect on it.
- R7: The buffer type of the second pin depends on `cfgGpo2PushPull`:
  - When `cfgGpo2PushPull`=1 (push-pull), `pin2Oe`=1 and `pin2Out` equals the level.
  - When `cfgGpo2PushPull`=0 (open-drain), a level of 1 gives `pin2Oe`=0. A level of 0 gives `pin2Oe`=1 and `pin2Out`=0.
- R8: When `cfgDc12RstEn`=0, the third pin is an open-drain output. Drive 0 gives `pin3Oe`=1. Drive 1 gives `pin3Oe`=0. When `cfgDc12RstEn`=1, `pin3Oe`=0 and the user bit is ignored.
- R9: `dcReset` is 1 within 4 cycles while `cfgDc12RstEn`=1 and `pin3In` is low. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cfgIo1Sel | input | 1 | 1 = first pin is the memory-reset input and drives the second pin |
| cfgGpo2PushPull | input | 1 | 1 = second pin push-pull, 0 = open-drain |
| cfgDc12RstEn | input | 1 | 1 = third pin is the converter reset input |
| userGpo1 | input | 1 | User drive bit, first pin |
| userGpo2 | input | 1 | User drive bit, second pin |
| userGpo3 | input | 1 | User drive bit, third pin |
| seqOvr1 | input | 1 | Sequencer override enable, first pin |
| seqVal1 | input | 1 | Sequencer drive value, first pin |
| seqOvr3 | input | 1 | Sequencer override enable, third pin |
| seqVal3 | input | 1 | Sequencer drive value, third pin |
| pgoodIn | input | 1 | Asynchronous power-good |
| pin1In | input | 1 | First pin input level |
| pin3In | input | 1 | Third pin input level |
| pin1Oe | output | 1 | First pin output enable |
| pin1Out | output | 1 | First pin output value |
| pin2Oe | output | 1 | Second pin output enable |
| pin2Out | output | 1 | Second pin output value |
| pin3Oe | output | 1 | Third pin output enable |
| pin3Out | output | 1 | Third pin output value |
| dcReset | output | 1 | Registered converter reset request, active high |

## Verification
The bench builds the block with the default `SYNC_STAGES`=2. This gives a three-register path from each asynchronous input to the held level and to `dcReset`, which keeps every waiting window at 4 cycles. A vector table covers the combinational modes, including overrides and both buffer types. Directed sequences then raise and drop power-good around changes of the memory-reset input, so that freezing, the reset-time low and the converter request are each observed at the pins.

// File: rtl/pinr_pkg.sv
package pinr_pkg;
  // Strobes from control to datapath for the memory-reset hold register.
  typedef struct packed {
    logic track;   // power-good high: sample the memory-reset input
    logic freeze;  // power-good just fell: keep the held value
  } pinr_strobe_t;

  // One pad drive.
  typedef struct packed {
    logic oe;
    logic out;
  } pinr_drive_t;
endpackage

// File: rtl/pinr_sync.sv
module pinr_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage[s] <= RST_VAL;
        end else if (s == 0) begin
          stage[s] <= asyncIn;
        end else begin
          stage[s] <= stage[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/pinr_ctrl.sv
module pinr_ctrl
  import pinr_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pgoodSync,
  output pinr_strobe_t strobe
);
  logic pgoodPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgoodPrev <= 1'b0;
    else        pgoodPrev <= pgoodSync;
  end

  always_comb begin
    strobe.track  = pgoodSync;
    strobe.freeze = pgoodPrev & ~pgoodSync;
  end

  AST_FREEZE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.freeze |=> !strobe.freeze); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.freeze && strobe.track)); // R4
endmodule

// File: rtl/pinr_datapath.sv
module pinr_datapath
  import pinr_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  pinr_strobe_t strobe,
  input  logic         cfgIo1Sel,
  input  logic         cfgGpo2PushPull,
  input  logic         cfgDc12RstEn,
  input  logic         userGpo1,
  input  logic         userGpo2,
  input  logic         userGpo3,
  input  logic         seqOvr1,
  input  logic         seqVal1,
  input  logic         seqOvr3,
  input  logic         seqVal3,
  input  logic         pin1Sync,
  input  logic         pin3Sync,
  output pinr_drive_t  drv1,
  output pinr_drive_t  drv2,
  output pinr_drive_t  drv3,
  output logic         dcReset
);
  logic heldLevel;
  logic level1, level2, level3;

  // Memory-reset hold register: cleared by power-on reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             heldLevel <= 1'b0;
    else if (strobe.freeze) heldLevel <= heldLevel;
    else if (strobe.track)  heldLevel <= pin1Sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcReset <= 1'b0;
    else        dcReset <= cfgDc12RstEn & ~pin3Sync;
  end

  always_comb begin
    level1 = seqOvr1 ? seqVal1 : userGpo1;
    level3 = seqOvr3 ? seqVal3 : userGpo3;
    level2 = cfgIo1Sel ? heldLevel : userGpo2;

    drv1.out = 1'b0;
    drv1.oe  = ~cfgIo1Sel & ~level1;

    drv3.out = 1'b0;
    drv3.oe  = ~cfgDc12RstEn & ~level3;

    if (cfgGpo2PushPull) begin
      drv2.oe  = 1'b1;
      drv2.out = level2;
    end else begin
      drv2.oe  = ~level2;
      drv2.out = 1'b0;
    end
  end

  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.track |=> $stable(heldLevel)); // R4
  AST_TRACK_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.track |=> heldLevel == $past(pin1Sync)); // R3
endmodule

// File: rtl/pmic_pin_router.sv
module pmic_pin_router
  import pinr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfgIo1Sel,
  input  logic cfgGpo2PushPull,
  input  logic cfgDc12RstEn,
  input  logic userGpo1,
  input  logic userGpo2,
  input  logic userGpo3,
  input  logic seqOvr1,
  input  logic seqVal1,
  input  logic seqOvr3,
  input  logic seqVal3,
  input  logic pgoodIn,
  input  logic pin1In,
  input  logic pin3In,
  output logic pin1Oe,
  output logic pin1Out,
  output logic pin2Oe,
  output logic pin2Out,
  output logic pin3Oe,
  output logic pin3Out,
  output logic dcReset
);
  localparam int NUM_ASYNC = 3;

  logic [NUM_ASYNC-1:0] syncBus;
  pinr_strobe_t strobe;
  pinr_drive_t  drv1, drv2, drv3;

  // bit 2 pgood (idle low), bit 1 pin3 (idle high), bit 0 pin1 (idle low)
  pinr_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .asyncIn({pgoodIn, pin3In, pin1In}),
    .syncOut(syncBus)
  );

  pinr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pgoodSync(syncBus[2]), .strobe(strobe)
  );

  pinr_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .cfgIo1Sel(cfgIo1Sel), .cfgGpo2PushPull(cfgGpo2PushPull),
    .cfgDc12RstEn(cfgDc12RstEn),
    .userGpo1(userGpo1), .userGpo2(userGpo2), .userGpo3(userGpo3),
    .seqOvr1(seqOvr1), .seqVal1(seqVal1), .seqOvr3(seqOvr3), .seqVal3(seqVal3),
    .pin1Sync(syncBus[0]), .pin3Sync(syncBus[1]),
    .drv1(drv1), .drv2(drv2), .drv3(drv3), .dcReset(dcReset)
  );

  assign pin1Oe  = drv1.oe;
  assign pin1Out = drv1.out;
  assign pin2Oe  = drv2.oe;
  assign pin2Out = drv2.out;
  assign pin3Oe  = drv3.oe;
  assign pin3Out = drv3.out;

  AST_PIN1_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin1Oe && pin1Out)); // R1
  AST_PIN2_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgGpo2PushPull |-> !(pin2Oe && pin2Out)); // R7
  AST_PIN3_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    cfgDc12RstEn |-> !pin3Oe); // R8
  AST_DCRESET_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    dcReset |-> $past(cfgDc12RstEn)); // R9
endmodule

// File: tb/pmic_pin_router_tb.sv
module pmic_pin_router_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgIo1Sel = 0, cfgGpo2PushPull = 0, cfgDc12RstEn = 0;
  logic userGpo1 = 0, userGpo2 = 0, userGpo3 = 0;
  logic seqOvr1 = 0, seqVal1 = 0, seqOvr3 = 0, seqVal3 = 0;
  logic pgoodIn = 0, pin1In = 0, pin3In = 1;
  logic pin1Oe, pin1Out, pin2Oe, pin2Out, pin3Oe, pin3Out, dcReset;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk; // 125 MHz

  pmic_pin_router u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfgIo1Sel(cfgIo1Sel), .cfgGpo2PushPull(cfgGpo2PushPull), .cfgDc12RstEn(cfgDc12RstEn),
    .userGpo1(userGpo1), .userGpo2(userGpo2), .userGpo3(userGpo3),
    .seqOvr1(seqOvr1), .seqVal1(seqVal1), .seqOvr3(seqOvr3), .seqVal3(seqVal3),
    .pgoodIn(pgoodIn), .pin1In(pin1In), .pin3In(pin3In),
    .pin1Oe(pin1Oe), .pin1Out(pin1Out), .pin2Oe(pin2Oe), .pin2Out(pin2Out),
    .pin3Oe(pin3Oe), .pin3Out(pin3Out), .dcReset(dcReset)
  );

  // {sel pp en u1 u2 u3 ovr1 sv1 ovr3 sv3} , {exp pin1Oe pin2Oe pin2Out pin3Oe}
  localparam logic [13:0] VEC [8] = '{
    {10'b0000000000, 4'b1101},
    {10'b0001110000, 4'b0000},
    {10'b0100100000, 4'b1111},
    {10'b0101010000, 4'b0100},
    {10'b0001011010, 4'b1101},
    {10'b0000101111, 4'b0000},
    {10'b0010000000, 4'b1100},
    {10'b0111100010, 4'b0110}
  };

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Reset with memory-reset mode, push-pull, power-good low
    cfgIo1Sel = 1; cfgGpo2PushPull = 1; pin1In = 1;
    waitCycles(3);
    rst_n = 1;
    waitCycles(5);
    check("R5 reset low pin2 {oe,out}", {2'b00, pin2Oe, pin2Out}, 4'b0010);
    check("R3 pin1 released in input mode", {3'b000, pin1Oe}, 4'b0000);
    check("R9 no dcReset when disabled", {3'b000, dcReset}, 4'b0000);

    // Pass-through while power-good high
    pgoodIn = 1; waitCycles(5);
    check("R3 follow high", {2'b00, pin2Oe, pin2Out}, 4'b0011);
    pin1In = 0; waitCycles(5);
    check("R3 follow low", {2'b00, pin2Oe, pin2Out}, 4'b0010);
    pin1In = 1; waitCycles(5);
    check("R3 follow high again", {2'b00, pin2Oe, pin2Out}, 4'b0011);

    // Freeze on power-good fall
    pgoodIn = 0; waitCycles(5);
    check("R4 frozen at fall", {2'b00, pin2Oe, pin2Out}, 4'b0011);
    pin1In = 0; waitCycles(6);
    check("R4 input ignored while low", {2'b00, pin2Oe, pin2Out}, 4'b0011);
    pgoodIn = 1; waitCycles(5);
    check("R3 follow resumes", {2'b00, pin2Oe, pin2Out}, 4'b0010);

    // Open-drain buffer in memory-reset mode
    cfgGpo2PushPull = 0; pin1In = 1; waitCycles(5);
    check("R7 open-drain high released", {2'b00, pin2Oe, pin2Out}, 4'b0000);
    pin1In = 0; waitCycles(5);
    check("R7 open-drain low driven", {2'b00, pin2Oe, pin2Out}, 4'b0010);

    // User-controlled vectors
    cfgIo1Sel = 0;
    for (int i = 0; i < 8; i++) begin
      {cfgIo1Sel, cfgGpo2PushPull, cfgDc12RstEn, userGpo1, userGpo2, userGpo3,
       seqOvr1, seqVal1, seqOvr3, seqVal3} = VEC[i][13:4];
      pin1In = i[0]; pgoodIn = i[1];
      waitCycles(5);
      check($sformatf("VEC%0d R1 R2 R6 R7 R8", i),
            {pin1Oe, pin2Oe, pin2Out, pin3Oe}, VEC[i][3:0]);
      check($sformatf("VEC%0d R1 R8 out low", i), {2'b00, pin1Out, pin3Out}, 4'b0000);
    end

    // Converter reset request
    seqOvr3 = 0; userGpo3 = 0; cfgDc12RstEn = 1; pin3In = 0; waitCycles(5);
    check("R9 request asserted", {3'b000, dcReset}, 4'b0001);
    check("R8 pin3 released, user ignored", {3'b000, pin3Oe}, 4'b0000);
    pin3In = 1; waitCycles(5);
    check("R9 request released", {3'b000, dcReset}, 4'b0000);
    cfgDc12RstEn = 0; pin3In = 0; waitCycles(5);
    check("R9 no request when disabled", {3'b000, dcReset}, 4'b0000);
    check("R8 pin3 user drive low", {3'b000, pin3Oe}, 4'b0001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule